// File: doc/BRIEF.md
# Queue-Fed Wide Stream Adder

This block takes operand words from two input queues and writes their sum to a third queue. All three words are 256 bits wide. Each input queue is reached through a FIFO read port: the block sees the word at the head of the queue, an empty flag, and a pop strobe it drives. The result leaves through a FIFO write port, which has a data bus, a full flag it observes, and a push strobe it drives.

One transfer takes the head word of both input queues in the same cycle and adds them across the full 256 bits. The sum is captured in a single output register that carries a valid flag. The register is pushed into the output queue on the next cycle if that queue has room. A new sum can enter the register in the cycle the old one leaves, so the block completes one add-and-transfer per clock when nothing stalls. If the output queue is full, the register keeps its word and the inputs stay untouched, so no result is lost or repeated.

Top module: `qstream_add`

## Requirements
- R1: `c_data` carries (A + B) mod 2^256, where A and B are the popped words. The carry out of bit 255 is discarded, and carries ripple correctly across every internal bit position.
- R2: `a_pop` and `b_pop` are always equal. They are high only in a cycle where both `a_empty` and `b_empty` are low.
- R3: No pop is issued while the output register holds an unpushed result and `c_full` is high. When both inputs are non-empty and the output register is empty or being pushed, a pop is issued.
- R4: A sum popped in cycle t is presented on `c_data`, with `c_push` high, in cycle t+1 whenever `c_full` is low in cycle t+1.
- R5: With both queues non-empty and `c_full` low, one pair is popped and one result is pushed in every cycle.
- R6: While `c_full` is high with a result pending, `c_push` stays low and `c_data` holds its value. Results are pushed exactly once each, in pop order.
- R7: While `rst` is high, `a_pop`, `b_pop` and `c_push` are low. After reset, no push is issued until a pair has been popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_data | input | 256 | Head word of operand queue A |
| a_empty | input | 1 | Operand queue A has no word |
| a_pop | output | 1 | Remove head word of queue A |
| b_data | input | 256 | Head word of operand queue B |
| b_empty | input | 1 | Operand queue B has no word |
| b_pop | output | 1 | Remove head word of queue B |
| c_data | output | 256 | Result word toward the output queue |
| c_full | input | 1 | Output queue cannot accept a word |
| c_push | output | 1 | Write `c_data` into the output queue |

## Verification
A push of the held result and the loading of a fresh sum can happen in the same cycle. This is the case that decides whether the block really reaches full throughput without dropping or duplicating a word. The bench provokes it with long unstalled bursts and with random empty and full patterns, where the full flag often drops just as a new pair becomes available. It judges the result by comparing every pushed word, in order, against a queue of sums the bench computes itself, and by comparing every pop and push strobe against the cycle the requirements predict.

// File: rtl/qsa_pkg.sv
package qsa_pkg;
    localparam int unsigned QSA_W   = 256;
    localparam int unsigned QSA_SEG = 64;

    typedef logic [QSA_W-1:0] qsa_word_t;

    typedef struct packed {
        logic      vld;
        qsa_word_t sum;
    } qsa_stage_t;

    function automatic logic qsa_both_ready(input logic a_empty, input logic b_empty);
        return !a_empty && !b_empty;
    endfunction
endpackage

// File: rtl/qsa_seg_adder.sv
module qsa_seg_adder #(
    parameter int unsigned W   = qsa_pkg::QSA_W,
    parameter int unsigned SEG = qsa_pkg::QSA_SEG
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam int unsigned NSEG = W / SEG;

    logic [NSEG-1:0] cin;
    assign cin[0] = 1'b0;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g < NSEG - 1) begin : g_mid
            assign {cin[g+1], s[g*SEG +: SEG]} =
                {1'b0, a[g*SEG +: SEG]} + {1'b0, b[g*SEG +: SEG]} + {{SEG{1'b0}}, cin[g]};
        end else begin : g_top
            // carry out of the top segment is dropped: sum is modulo 2^W
            assign s[g*SEG +: SEG] =
                a[g*SEG +: SEG] + b[g*SEG +: SEG] + {{(SEG-1){1'b0}}, cin[g]};
        end
    end
endmodule

// File: rtl/qsa_join.sv
module qsa_join (
    input  logic clk,
    input  logic rst,
    input  logic a_empty,
    input  logic b_empty,
    input  logic can_accept,
    output logic fire
);
    import qsa_pkg::*;

    assign fire = !rst && qsa_both_ready(a_empty, b_empty) && can_accept;

    AST_FIRE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        fire |-> (!a_empty && !b_empty)); // R2
    AST_FIRE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
        fire |-> can_accept); // R3
endmodule

// File: rtl/qsa_out_stage.sv
module qsa_out_stage #(
    parameter int unsigned W = qsa_pkg::QSA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         out_full,
    output logic [W-1:0] dout,
    output logic         push,
    output logic         can_accept
);
    logic         vld_q;
    logic [W-1:0] sum_q;

    assign push       = !rst && vld_q && !out_full;
    assign can_accept = !vld_q || !out_full;
    assign dout       = sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
        end else if (push) begin
            vld_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            sum_q <= din;
        end
    end

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (vld_q && out_full) |=> (vld_q && $stable(sum_q))); // R6
    AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        load |=> vld_q); // R4
endmodule

// File: rtl/qstream_add.sv
module qstream_add (
    input  logic         clk,
    input  logic         rst,
    input  logic [255:0] a_data,
    input  logic         a_empty,
    output logic         a_pop,
    input  logic [255:0] b_data,
    input  logic         b_empty,
    output logic         b_pop,
    output logic [255:0] c_data,
    input  logic         c_full,
    output logic         c_push
);
    import qsa_pkg::*;

    logic      fire;
    logic      can_accept;
    qsa_word_t sum_c;

    qsa_join u_join (
        .clk        (clk),
        .rst        (rst),
        .a_empty    (a_empty),
        .b_empty    (b_empty),
        .can_accept (can_accept),
        .fire       (fire)
    );

    qsa_seg_adder #(.W(QSA_W), .SEG(QSA_SEG)) u_add (
        .a (a_data),
        .b (b_data),
        .s (sum_c)
    );

    qsa_out_stage #(.W(QSA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (fire),
        .din        (sum_c),
        .out_full   (c_full),
        .dout       (c_data),
        .push       (c_push),
        .can_accept (can_accept)
    );

    assign a_pop = fire;
    assign b_pop = fire;

    AST_SUM_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        a_pop |=> (c_data == ($past(a_data) + $past(b_data)))); // R1
    AST_PUSH_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        (a_pop && !$past(rst)) |=> (c_full || c_push)); // R4

    always_ff @(posedge clk) begin
        if (rst) begin
            AST_QUIET_IN_RESET: assert (!a_pop && !b_pop && !c_push); // R7
        end
    end
endmodule

// File: tb/sim_qstream_add.sv
`timescale 1ns/1ps
module sim_qstream_add;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] a_data = '0, b_data = '0;
    logic         a_empty = 1'b1, b_empty = 1'b1, c_full = 1'b0;
    logic         a_pop, b_pop, c_push;
    logic [255:0] c_data;

    always #2.5 clk = ~clk;

    qstream_add u0 (.clk(clk), .rst(rst), .a_data(a_data), .a_empty(a_empty), .a_pop(a_pop),
                    .b_data(b_data), .b_empty(b_empty), .b_pop(b_pop),
                    .c_data(c_data), .c_full(c_full), .c_push(c_push));

    localparam int NV = 8;
    localparam logic [255:0] ONES = {256{1'b1}};
    localparam logic [255:0] VA [NV] = '{256'd0, ONES, ONES, (256'd1 << 64) - 256'd1,
        (256'd1 << 192) - 256'd1, 256'd1 << 255, 256'd123456789, {128{2'b01}}};
    localparam logic [255:0] VB [NV] = '{256'd0, 256'd1, ONES, 256'd1,
        256'd1, 256'd1 << 255, 256'd987654321, {128{2'b10}}};
    localparam logic [255:0] VS [NV] = '{256'd0, 256'd0, {{255{1'b1}}, 1'b0}, 256'd1 << 64,
        256'd1 << 192, 256'd0, 256'd1111111110, ONES};

    int tests = 0, fails = 0;
    logic [255:0] qa [0:511];
    logic [255:0] qb [0:511];
    logic [255:0] ex [0:511];
    int na = 0, ia = 0, et = 0, eh = 0;
    logic vld_m = 1'b0;
    int pops_seen = 0, pushes_seen = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one clock: drive inputs at negedge, judge strobes, advance bench queues after posedge
    task automatic cyc(input bit sa, input bit sb, input bit full);
        bit ae, be, exp_pop, exp_push, got_pop, got_push;
        logic [255:0] sum_in;
        @(negedge clk);
        ae = (ia >= na) || sa;
        be = (ia >= na) || sb;
        a_empty = ae; b_empty = be; c_full = full;
        a_data = (ia < na) ? qa[ia] : '0;
        b_data = (ia < na) ? qb[ia] : '0;
        #1;
        got_pop = a_pop; got_push = c_push;
        chk(a_pop == b_pop, "R2 pops paired", {255'd0, a_pop}, {255'd0, b_pop});
        exp_pop  = !rst && !ae && !be && (!vld_m || !full);
        exp_push = !rst && vld_m && !full;
        chk(got_pop == exp_pop, "R3 pop decision", {255'd0, got_pop}, {255'd0, exp_pop});
        chk(got_push == exp_push, "R4 R6 push decision", {255'd0, got_push}, {255'd0, exp_push});
        if (vld_m && eh < et)
            chk(c_data === ex[eh], "R1 R6 result order/value", c_data, ex[eh]);
        sum_in = a_data + b_data;
        @(posedge clk);
        #1;
        if (rst) begin
            vld_m = 1'b0; eh = et;
        end else begin
            if (got_push) begin eh++; pushes_seen++; end
            if (got_pop) begin
                ex[et] = (et < NV) ? VS[et] : sum_in;
                et++; ia++; pops_seen++;
                vld_m = 1'b1;
            end else if (got_push) begin
                vld_m = 1'b0;
            end
        end
    endtask

    initial begin
        #(200000 * 5.0);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NV; k++) begin qa[k] = VA[k]; qb[k] = VB[k]; end
        na = NV;
        // R7: reset held with both queues non-empty
        rst = 1'b1;
        for (int k = 0; k < 3; k++) cyc(0, 0, 0);
        chk(ia == 0, "R7 no pop in reset", 256'(ia), 256'd0);
        rst = 1'b0;
        // R5 R1: table walked with no stalls, one pair per cycle
        for (int k = 0; k < NV; k++) cyc(0, 0, 0);
        chk(pops_seen == NV, "R5 pops per cycle", 256'(pops_seen), 256'(NV));
        chk(pushes_seen == NV - 1, "R5 pushes per cycle", 256'(pushes_seen), 256'(NV - 1));
        cyc(0, 0, 0);
        chk(pushes_seen == NV, "R4 last push one cycle later", 256'(pushes_seen), 256'(NV));
        // R2 R3 R6: random operands under random stalls
        for (int k = NV; k < 400; k++) begin
            for (int w = 0; w < 8; w++) begin
                qa[k][w*32 +: 32] = $urandom;
                qb[k][w*32 +: 32] = $urandom;
            end
        end
        na = 400;
        for (int c = 0; c < 1500; c++)
            cyc($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
        for (int c = 0; c < 20; c++) cyc(0, 0, 0);
        chk(pushes_seen == 400, "R6 every result pushed once", 256'(pushes_seen), 256'd400);
        // R6: long full stall holding one result
        for (int k = 400; k < 404; k++) begin qa[k] = 256'(k); qb[k] = ONES; end
        na = 404;
        for (int c = 0; c < 10; c++) cyc(0, 0, 1);
        chk(ia == 401, "R6 inputs held while full", 256'(ia), 256'd401);
        // R7: reset with a pending result, then no push afterwards
        rst = 1'b1;
        cyc(1, 1, 0);
        rst = 1'b0;
        na = ia;
        cyc(1, 1, 0);
        chk(c_push == 1'b0, "R7 valid cleared by reset", {255'd0, c_push}, 256'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule